// File: doc/BRIEF.md
# Split-execute pipeline hazard controller

This block makes the hazard decisions for a six-stage in-order pipeline whose execute step is split in two. The stages are fetch, decode, EX1, EX2, memory and write-back. EX1 compares the two operands of a branch and forms its target. EX2 runs the ALU for arithmetic and address work, and it redirects the PC when a branch turns out taken. All operand forwarding lands in EX1. A result therefore has to be computed, and not just in flight, before the next instruction reaches EX1.

The controller is purely combinational. Each stage register supplies its opcode and its register fields, and EX2 supplies the branch outcome. The controller returns four things: a stall that freezes the PC and the decode register, a bubble that puts a no-op into EX1, a forward-source select for each EX1 operand, and a squash that turns the three younger instructions into no-ops.

Top module: `sx_hazard_ctl`

## Requirements
- R1: Opcodes are add=0, nor=1, lw=2, sw=3, beq=4, halt=6 and noop=7. Only add and nor (which write their third field) and lw (which writes its regB field) produce a result. Register 0 is never a hazard source and never a forward source.
- R2: When the decode instruction reads a register that the EX1 instruction (held in ID/EX1) writes with add or nor, stall is 1 for that cycle. Once the producer has moved one stage on, stall is 0.
- R3: When the decode instruction reads the register loaded by an lw in ID/EX1, stall is 1. It stays 1 in the following cycle, while that lw sits in EX1/EX2, so the consumer is held for two cycles in all.
- R4: An lw in EX1/EX2 whose destination the decode instruction reads causes stall=1. An add or nor in EX1/EX2 causes no stall.
- R5: add, nor, sw and beq read both regA and regB. lw reads only regA. halt and noop read nothing.
- R6: bubble equals stall in every cycle. A quiet pipeline, with every stage holding a noop, gives stall=0, bubble=0, squash=0 and both selects 0.
- R7: squash equals the EX2 taken flag in the same cycle. While squash is 1, stall and bubble are 0.
- R8: Forward select encoding: 0 means the register file, 1 means EX2/MEM, 2 means MEM/WB and 3 means WB/END. When more than one stage writes the register, the youngest matching stage wins.
- R9: An lw in EX2/MEM is never chosen as a forward source, because its data is not ready yet. An older matching stage is chosen instead.
- R10: Consider the program lw r1; lw r2; beq r2,r2,+1 (taken); two adds; a further add; halt, with the first fetch in cycle 0. It gives exactly 2 stall cycles and one squash, in cycle 7, which flushes 3 real instructions. The halt reaches EX1/EX2 in cycle 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_op | input | 3 | opcode in IF/ID |
| ifid_ra | input | RW | regA field in IF/ID |
| ifid_rb | input | RW | regB field in IF/ID |
| idex_op | input | 3 | opcode in ID/EX1 |
| idex_ra | input | RW | regA field in ID/EX1 |
| idex_rb | input | RW | regB field in ID/EX1 |
| idex_rd | input | RW | destination field in ID/EX1 |
| exex_op | input | 3 | opcode in EX1/EX2 |
| exex_rb | input | RW | regB field in EX1/EX2 |
| exex_rd | input | RW | destination field in EX1/EX2 |
| exmem_op | input | 3 | opcode in EX2/MEM |
| exmem_rb | input | RW | regB field in EX2/MEM |
| exmem_rd | input | RW | destination field in EX2/MEM |
| memwb_op | input | 3 | opcode in MEM/WB |
| memwb_rb | input | RW | regB field in MEM/WB |
| memwb_rd | input | RW | destination field in MEM/WB |
| wbend_op | input | 3 | opcode in WB/END |
| wbend_rb | input | RW | regB field in WB/END |
| wbend_rd | input | RW | destination field in WB/END |
| ex2_taken | input | 1 | branch in EX2 resolved taken |
| stall | output | 1 | hold PC and IF/ID |
| bubble | output | 1 | load a noop into ID/EX1 |
| squash | output | 1 | turn IF, IF/ID and ID/EX1 into noops |
| fwd_a | output | 2 | EX1 regA source select |
| fwd_b | output | 2 | EX1 regB source select |

## Verification
A table of stage snapshots places one producer at each distance from the consumer. Some producers are ALU ops and some are loads, so a single-cycle stall can be told apart from the two-cycle load hold. Other rows swap the reading opcode between lw, sw and add to separate operand usage, and use writes to register 0 and beq destination fields to show that those never count as producers. Rows with several matching writers at once expose the order of forwarding priority and the skip over a load that is still in EX2/MEM. A closed-loop run of a load-then-branch program fixes the exact stall count, the squash cycle and the squash depth.

// File: rtl/sx_hazard_ctl.sv
`timescale 1ns/1ps
module sx_hazard_ctl #(
  parameter int RW = 3
) (
  input  logic [2:0]    ifid_op,
  input  logic [RW-1:0] ifid_ra,
  input  logic [RW-1:0] ifid_rb,
  input  logic [2:0]    idex_op,
  input  logic [RW-1:0] idex_ra,
  input  logic [RW-1:0] idex_rb,
  input  logic [RW-1:0] idex_rd,
  input  logic [2:0]    exex_op,
  input  logic [RW-1:0] exex_rb,
  input  logic [RW-1:0] exex_rd,
  input  logic [2:0]    exmem_op,
  input  logic [RW-1:0] exmem_rb,
  input  logic [RW-1:0] exmem_rd,
  input  logic [2:0]    memwb_op,
  input  logic [RW-1:0] memwb_rb,
  input  logic [RW-1:0] memwb_rd,
  input  logic [2:0]    wbend_op,
  input  logic [RW-1:0] wbend_rb,
  input  logic [RW-1:0] wbend_rd,
  input  logic          ex2_taken,
  output logic          stall,
  output logic          bubble,
  output logic          squash,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b
);
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_NOR = 3'd1;
  localparam logic [2:0] OP_LW  = 3'd2;
  localparam logic [2:0] OP_SW  = 3'd3;
  localparam logic [2:0] OP_BEQ = 3'd4;
  localparam logic [RW-1:0] R0  = '0;

  function automatic logic [RW-1:0] dest_of(input logic [2:0] op,
                                            input logic [RW-1:0] rb,
                                            input logic [RW-1:0] rd);
    if (op == OP_LW) return rb;
    if (op == OP_ADD || op == OP_NOR) return rd;
    return R0;
  endfunction

  function automatic logic reads_a(input logic [2:0] op);
    return op == OP_ADD || op == OP_NOR || op == OP_LW || op == OP_SW || op == OP_BEQ;
  endfunction

  function automatic logic reads_b(input logic [2:0] op);
    return op == OP_ADD || op == OP_NOR || op == OP_SW || op == OP_BEQ;
  endfunction

  logic [RW-1:0] w_idex, w_exex, w_exmem, w_memwb, w_wbend;
  assign w_idex  = dest_of(idex_op,  idex_rb,  idex_rd);
  assign w_exex  = dest_of(exex_op,  exex_rb,  exex_rd);
  assign w_exmem = dest_of(exmem_op, exmem_rb, exmem_rd);
  assign w_memwb = dest_of(memwb_op, memwb_rb, memwb_rd);
  assign w_wbend = dest_of(wbend_op, wbend_rb, wbend_rd);

  function automatic logic needs(input logic use_it, input logic [RW-1:0] src,
                                 input logic [RW-1:0] w);
    return use_it && src != R0 && src == w;
  endfunction

  logic near_hit, far_hit;
  assign near_hit = needs(reads_a(ifid_op), ifid_ra, w_idex) |
                    needs(reads_b(ifid_op), ifid_rb, w_idex);
  assign far_hit  = (exex_op == OP_LW) &&
                    (needs(reads_a(ifid_op), ifid_ra, w_exex) |
                     needs(reads_b(ifid_op), ifid_rb, w_exex));

  assign squash = ex2_taken;
  assign stall  = (near_hit | far_hit) & ~ex2_taken;
  assign bubble = stall;

  function automatic logic [1:0] pick(input logic use_it, input logic [RW-1:0] src,
                                      input logic exm_ok, input logic [RW-1:0] wm,
                                      input logic [RW-1:0] ww, input logic [RW-1:0] we);
    if (!use_it || src == R0) return 2'd0;
    if (exm_ok && src == wm) return 2'd1;
    if (src == ww) return 2'd2;
    if (src == we) return 2'd3;
    return 2'd0;
  endfunction

  logic exm_ok;
  assign exm_ok = exmem_op != OP_LW;
  assign fwd_a = pick(reads_a(idex_op), idex_ra, exm_ok, w_exmem, w_memwb, w_wbend);
  assign fwd_b = pick(reads_b(idex_op), idex_rb, exm_ok, w_exmem, w_memwb, w_wbend);

  always_comb begin
    if (!$isunknown({stall, squash})) begin
      // R7
      squash_prio_chk: assert (!(stall && squash));
    end
    if (!$isunknown({stall, ifid_op})) begin
      // R5
      stall_reader_chk: assert (!stall || reads_a(ifid_op));
    end
    if (!$isunknown({fwd_a, fwd_b, exmem_op})) begin
      // R9
      no_lw_fwd_chk: assert (!((fwd_a == 2'd1 || fwd_b == 2'd1) && exmem_op == OP_LW));
    end
    if (!$isunknown({fwd_a, fwd_b, idex_ra, idex_rb})) begin
      // R1
      zero_src_chk: assert (!((fwd_a != 2'd0 && idex_ra == R0) ||
                              (fwd_b != 2'd0 && idex_rb == R0)));
    end
  end
endmodule

// File: tb/sim_sx_hazard_ctl.sv
`timescale 1ns/1ps
module sim_sx_hazard_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] ifid_op, ifid_ra, ifid_rb;
  logic [2:0] idex_op, idex_ra, idex_rb, idex_rd;
  logic [2:0] exex_op, exex_rb, exex_rd;
  logic [2:0] exmem_op, exmem_rb, exmem_rd;
  logic [2:0] memwb_op, memwb_rb, memwb_rd;
  logic [2:0] wbend_op, wbend_rb, wbend_rd;
  logic       ex2_taken;
  logic       stall, bubble, squash;
  logic [1:0] fwd_a, fwd_b;

  sx_hazard_ctl #(.RW(3)) u0 (
    .ifid_op(ifid_op), .ifid_ra(ifid_ra), .ifid_rb(ifid_rb),
    .idex_op(idex_op), .idex_ra(idex_ra), .idex_rb(idex_rb), .idex_rd(idex_rd),
    .exex_op(exex_op), .exex_rb(exex_rb), .exex_rd(exex_rd),
    .exmem_op(exmem_op), .exmem_rb(exmem_rb), .exmem_rd(exmem_rd),
    .memwb_op(memwb_op), .memwb_rb(memwb_rb), .memwb_rd(memwb_rd),
    .wbend_op(wbend_op), .wbend_rb(wbend_rb), .wbend_rd(wbend_rd),
    .ex2_taken(ex2_taken), .stall(stall), .bubble(bubble), .squash(squash),
    .fwd_a(fwd_a), .fwd_b(fwd_b));

  int nchk = 0;
  int nfail = 0;

  typedef struct packed {
    int t;
    int iop; int ia; int ib;
    int dop; int da; int db; int dd;
    int xop; int xb; int xd;
    int mop; int mb; int md;
    int wop; int wb; int wd;
    int eop; int eb; int ed;
    int tk; int st; int sq; int fa; int fb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{6, 7,0,0, 7,0,0,0, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 0,0,0,0}, // R6 quiet pipeline
    '{2, 0,1,2, 0,0,0,1, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 1,0,0,0}, // R2 ALU one ahead
    '{2, 0,1,2, 7,0,0,0, 0,0,1, 7,0,0, 7,0,0, 7,0,0, 0, 0,0,0,0}, // R2 ALU moved on
    '{3, 4,2,2, 2,0,2,0, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 1,0,0,0}, // R3 lw one ahead
    '{3, 4,2,2, 7,0,0,0, 2,2,0, 7,0,0, 7,0,0, 7,0,0, 0, 1,0,0,0}, // R3 second hold
    '{4, 0,3,0, 7,0,0,0, 0,0,3, 7,0,0, 7,0,0, 7,0,0, 0, 0,0,0,0}, // R4 ALU in EX1/EX2
    '{4, 3,0,5, 7,0,0,0, 2,5,0, 7,0,0, 7,0,0, 7,0,0, 0, 1,0,0,0}, // R4 lw in EX1/EX2
    '{5, 2,0,1, 0,0,0,1, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 0,0,0,0}, // R5 lw ignores regB
    '{5, 3,0,1, 0,0,0,1, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 1,0,0,0}, // R5 sw reads regB
    '{1, 0,0,0, 0,0,0,0, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 0,0,0,0}, // R1 r0 no hazard
    '{1, 0,5,0, 4,0,0,5, 7,0,0, 7,0,0, 7,0,0, 7,0,0, 0, 0,0,0,0}, // R1 beq writes nothing
    '{7, 0,1,2, 0,0,0,1, 4,0,0, 7,0,0, 7,0,0, 7,0,0, 1, 0,1,0,0}, // R7 squash wins
    '{8, 7,0,0, 0,1,2,3, 7,0,0, 0,0,1, 0,0,2, 0,0,1, 0, 0,0,1,2}, // R8 youngest first
    '{8, 7,0,0, 1,3,4,5, 7,0,0, 7,0,0, 2,3,0, 1,0,4, 0, 0,0,2,3}, // R8 older stages
    '{9, 7,0,0, 0,2,0,1, 7,0,0, 2,2,0, 0,0,2, 7,0,0, 0, 0,0,2,0}  // R9 skip lw in MEM
  };

  task automatic chk(input int tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] op; logic [2:0] ra; logic [2:0] rb; logic [2:0] rd; logic [3:0] pc;
  } tok_t;
  localparam tok_t NOP = '{3'd7, 3'd0, 3'd0, 3'd0, 4'd0};

  function automatic tok_t imem(input logic [3:0] p);
    tok_t t;
    case (p)
      4'd0: t = '{3'd2, 3'd0, 3'd1, 3'd0, p};
      4'd1: t = '{3'd2, 3'd0, 3'd2, 3'd1, p};
      4'd2: t = '{3'd4, 3'd2, 3'd2, 3'd1, p};
      4'd3: t = '{3'd0, 3'd1, 3'd1, 3'd1, p};
      4'd4: t = '{3'd0, 3'd1, 3'd2, 3'd1, p};
      4'd5: t = '{3'd0, 3'd2, 3'd2, 3'd3, p};
      4'd6: t = '{3'd6, 3'd0, 3'd0, 3'd0, p};
      default: t = NOP;
    endcase
    return t;
  endfunction

  tok_t s_if, s_id, s_x, s_m, s_w, s_e;
  logic [3:0] pc;

  task automatic drive_model();
    ifid_op = s_if.op; ifid_ra = s_if.ra; ifid_rb = s_if.rb;
    idex_op = s_id.op; idex_ra = s_id.ra; idex_rb = s_id.rb; idex_rd = s_id.rd;
    exex_op = s_x.op; exex_rb = s_x.rb; exex_rd = s_x.rd;
    exmem_op = s_m.op; exmem_rb = s_m.rb; exmem_rd = s_m.rd;
    memwb_op = s_w.op; memwb_rb = s_w.rb; memwb_rd = s_w.rd;
    wbend_op = s_e.op; wbend_rb = s_e.rb; wbend_rd = s_e.rd;
    ex2_taken = (s_x.op == 3'd4);
  endtask

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int stalls, squashes, sq_cyc, flushed, halt_cyc;
    s_if = NOP; s_id = NOP; s_x = NOP; s_m = NOP; s_w = NOP; s_e = NOP; pc = 4'd0;
    drive_model();
    @(posedge clk);
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      ifid_op = 3'(v.iop); ifid_ra = 3'(v.ia); ifid_rb = 3'(v.ib);
      idex_op = 3'(v.dop); idex_ra = 3'(v.da); idex_rb = 3'(v.db); idex_rd = 3'(v.dd);
      exex_op = 3'(v.xop); exex_rb = 3'(v.xb); exex_rd = 3'(v.xd);
      exmem_op = 3'(v.mop); exmem_rb = 3'(v.mb); exmem_rd = 3'(v.md);
      memwb_op = 3'(v.wop); memwb_rb = 3'(v.wb); memwb_rd = 3'(v.wd);
      wbend_op = 3'(v.eop); wbend_rb = 3'(v.eb); wbend_rd = 3'(v.ed);
      ex2_taken = v.tk[0];
      @(negedge clk);
      chk(v.t, $sformatf("vec%0d stall", k), int'(stall), v.st);
      chk(6, $sformatf("vec%0d bubble", k), int'(bubble), v.st); // R6
      chk(v.t, $sformatf("vec%0d squash", k), int'(squash), v.sq);
      chk(v.t, $sformatf("vec%0d fwd_a", k), int'(fwd_a), v.fa);
      chk(v.t, $sformatf("vec%0d fwd_b", k), int'(fwd_b), v.fb);
      @(posedge clk);
    end

    // R10 closed-loop program run
    stalls = 0; squashes = 0; sq_cyc = -1; flushed = 0; halt_cyc = -1;
    s_if = NOP; s_id = NOP; s_x = NOP; s_m = NOP; s_w = NOP; s_e = NOP; pc = 4'd0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      logic st, sq;
      logic [3:0] tgt;
      drive_model();
      @(negedge clk);
      st = stall; sq = squash;
      if (st) stalls++;
      if (s_x.op == 3'd6 && halt_cyc < 0) halt_cyc = cyc;
      if (sq) begin
        squashes++;
        sq_cyc = cyc;
        flushed = int'(s_id.op != 3'd7) + int'(s_if.op != 3'd7) + int'(imem(pc).op != 3'd7);
      end
      tgt = 4'(s_x.pc + 4'd1 + 4'(s_x.rd));
      s_e = s_w; s_w = s_m; s_m = s_x;
      if (sq) begin
        s_x = NOP; s_id = NOP; s_if = NOP; pc = tgt;
      end else if (st) begin
        s_x = s_id; s_id = NOP;
      end else begin
        s_x = s_id; s_id = s_if; s_if = imem(pc); pc = pc + 4'd1;
      end
      @(posedge clk);
    end
    chk(10, "program stall cycles", stalls, 2);
    chk(10, "program squash events", squashes, 1);
    chk(10, "program squash cycle", sq_cyc, 7);
    chk(10, "program flushed count", flushed, 3);
    chk(10, "program halt in EX1/EX2 cycle", halt_cyc, 13);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule